// File: doc/BRIEF.md
# Windowed Command and Status Port

This block is the host-facing control register of a network adapter. The host writes one 16-bit word. The upper five bits of that word select an operation and the lower eleven bits carry its argument. A read of the same port returns a registered 16-bit status word. The status word holds four things: the register window that is currently selected, a busy flag, seven latched event bits and a summary interrupt-pending bit. The block also drives one interrupt line. It gives the rest of the adapter level enables for the receiver and transmitter, and single-cycle pulses for the receiver, transmitter and global resets.

Event sources such as receive or transmit completion enter as one-cycle pulses on `evt_pulse`. The host clears events with an acknowledge operation, which carries a bitmask in its argument. Two masks shape what the host sees. The interrupt mask selects which events drive the interrupt line. The visibility mask selects which events appear on a status read. The host never changes the window through an address bit: window selection is itself an operation. After any accepted operation the port stays busy for a short time, and it ignores writes while busy.

Top module: `cmdstat_port`

## Requirements
- R1: After a synchronous reset, status reads 0x0000, `irq`, `rx_enable` and `tx_enable` are low, the interrupt mask is all zeros and the visibility mask is all ones.
- R2: Opcode 1 loads the window from argument bits 2..0. Status bits 15..13 show the selected window one cycle after the write.
- R3: Status bit 12 is high while the port is busy. An accepted operation makes the port busy for 1 cycle. Opcodes 0, 5 and 11 make it busy for `RST_CYCLES` cycles (default 8). Any write arriving while the port is busy is dropped.
- R4: A pulse on `evt_pulse[i]` latches event i, and the event shows on status bit i+1. Status bits 7..1 are, from high to low: statistics update, interrupt requested, receive early, receive complete, transmit space available, transmit complete, adapter failure.
- R5: Opcode 13 clears each latched event i whose argument bit i+1 is one. If an event pulse arrives in the same cycle as its acknowledge, the event stays set.
- R6: Opcode 12 latches the interrupt-requested event (status bit 6).
- R7: Opcode 14 loads the interrupt mask from argument bits 7..1. `irq` and status bit 0 are high exactly when some latched event is unmasked.
- R8: Opcode 15 loads the visibility mask from argument bits 7..1. A hidden event reads as zero on status bits 7..1 but stays pending for `irq`.
- R9: Opcode 4 sets `rx_enable` and opcode 3 clears it. Opcode 5 clears it and pulses `rx_reset_pulse` for one cycle. Each of these ignores its argument.
- R10: Opcode 9 sets `tx_enable` and opcode 10 clears it. Opcode 11 clears it and pulses `tx_reset_pulse` for one cycle.
- R11: Opcode 0 pulses `global_reset_pulse` for one cycle. It returns the window, the events, both masks and both enables to their reset values.
- R12: Opcodes 2, 6, 7, 8 and 16 to 31 change nothing and do not make the port busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Write strobe for the command word |
| cmd_data | input | 16 | Command word: opcode in bits 15..11, argument in bits 10..0 |
| evt_pulse | input | 7 | One-cycle event pulses; bit i maps to status bit i+1 |
| status | output | 16 | Registered status word |
| irq | output | 1 | Interrupt request |
| rx_enable | output | 1 | Receiver enable level |
| tx_enable | output | 1 | Transmitter enable level |
| rx_reset_pulse | output | 1 | One-cycle receiver reset |
| tx_reset_pulse | output | 1 | One-cycle transmitter reset |
| global_reset_pulse | output | 1 | One-cycle adapter reset |

## Verification
Some rules hold on every cycle, and the assertions check those. Each event pulse is latched. An acknowledge without a competing pulse clears its bit. A short operation holds busy for exactly one cycle. A write that arrives while busy leaves the window unchanged. Each reset pulse lasts one cycle and coincides with its enable being cleared. The bench scenarios cover what depends on a sequence of operations: how the two masks combine, that arguments are ignored, that unknown opcodes have no effect, how long the reset-class busy window lasts, and that a global reset returns the masks to their defaults.

// File: rtl/cmdstat_pkg.sv
package cmdstat_pkg;
  localparam int WORD_W = 16;
  localparam int OP_W   = 5;
  localparam int ARG_W  = WORD_W - OP_W;

  typedef enum logic [OP_W-1:0] {
    OP_GLOBAL_RST = 5'd0,
    OP_WINDOW     = 5'd1,
    OP_RX_OFF     = 5'd3,
    OP_RX_ON      = 5'd4,
    OP_RX_RST     = 5'd5,
    OP_TX_ON      = 5'd9,
    OP_TX_OFF     = 5'd10,
    OP_TX_RST     = 5'd11,
    OP_REQ_IRQ    = 5'd12,
    OP_ACK        = 5'd13,
    OP_IRQ_MASK   = 5'd14,
    OP_VIS_MASK   = 5'd15
  } opcode_e;

  typedef struct packed {
    logic glob;
    logic win;
    logic rx_off;
    logic rx_on;
    logic rx_rst;
    logic tx_on;
    logic tx_off;
    logic tx_rst;
    logic req;
    logic ack;
    logic imask;
    logic vmask;
  } cmd_t;
endpackage

// File: rtl/cmdstat_decode.sv
module cmdstat_decode
  import cmdstat_pkg::*;
(
  input  logic              wr,
  input  logic [WORD_W-1:0] data,
  input  logic              busy,
  output cmd_t              cmd,
  output logic              start,
  output logic              long_op,
  output logic [ARG_W-1:0]  arg
);
  logic [OP_W-1:0] op;
  logic            known;
  cmd_t            hit;

  assign op  = data[WORD_W-1:ARG_W];
  assign arg = data[ARG_W-1:0];

  always_comb begin
    hit   = '0;
    known = 1'b1;
    case (op)
      OP_GLOBAL_RST: hit.glob   = 1'b1;
      OP_WINDOW:     hit.win    = 1'b1;
      OP_RX_OFF:     hit.rx_off = 1'b1;
      OP_RX_ON:      hit.rx_on  = 1'b1;
      OP_RX_RST:     hit.rx_rst = 1'b1;
      OP_TX_ON:      hit.tx_on  = 1'b1;
      OP_TX_OFF:     hit.tx_off = 1'b1;
      OP_TX_RST:     hit.tx_rst = 1'b1;
      OP_REQ_IRQ:    hit.req    = 1'b1;
      OP_ACK:        hit.ack    = 1'b1;
      OP_IRQ_MASK:   hit.imask  = 1'b1;
      OP_VIS_MASK:   hit.vmask  = 1'b1;
      default:       known      = 1'b0;
    endcase
  end

  assign start   = wr && !busy && known;
  assign cmd     = start ? hit : '0;
  assign long_op = hit.glob || hit.rx_rst || hit.tx_rst;
endmodule

// File: rtl/cmdstat_busy.sv
module cmdstat_busy #(
  parameter int RST_CYCLES = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic long_op,
  output logic busy
);
  localparam int CNT_W = $clog2(RST_CYCLES + 1);
  localparam logic [CNT_W-1:0] LONG_LOAD  = CNT_W'(RST_CYCLES);
  localparam logic [CNT_W-1:0] SHORT_LOAD = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (start)
      cnt_q <= long_op ? LONG_LOAD : SHORT_LOAD;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  assign busy = (cnt_q != '0);

  // R3: a short operation keeps the port busy for exactly one cycle
  a_r3_short_busy: assert property (@(posedge clk) disable iff (rst)
    (start && !long_op) |=> busy ##1 !busy);
  // R3: no operation starts while busy
  a_r3_no_start_busy: assert property (@(posedge clk) disable iff (rst)
    busy |-> !start);
endmodule

// File: rtl/cmdstat_events.sv
module cmdstat_events #(
  parameter int EVT_N   = 7,
  parameter int REQ_IDX = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_all,
  input  logic [EVT_N-1:0] ev_in,
  input  logic [EVT_N-1:0] arg_bits,
  input  logic             ack_en,
  input  logic             req_en,
  input  logic             imask_en,
  input  logic             vmask_en,
  output logic [EVT_N-1:0] vis_q,
  output logic             irq_q
);
  logic [EVT_N-1:0] flags_q, flags_d;
  logic [EVT_N-1:0] imask_q, imask_d;
  logic [EVT_N-1:0] vmask_q, vmask_d;

  for (genvar i = 0; i < EVT_N; i++) begin : g_bit
    logic set_b, clr_b;
    assign set_b = ev_in[i] || (req_en && (i == REQ_IDX));
    assign clr_b = ack_en && arg_bits[i];
    assign flags_d[i] = !clr_all && (set_b || (flags_q[i] && !clr_b));

    // R4: an event pulse is always latched
    a_r4_event_sets: assert property (@(posedge clk) disable iff (rst)
      (ev_in[i] && !clr_all) |=> flags_q[i]);
    // R5: an acknowledge without a competing pulse clears the bit
    a_r5_ack_clears: assert property (@(posedge clk) disable iff (rst)
      (ack_en && arg_bits[i] && !ev_in[i]) |=> !flags_q[i]);
  end

  assign imask_d = clr_all ? '0 : (imask_en ? arg_bits : imask_q);
  assign vmask_d = clr_all ? '1 : (vmask_en ? arg_bits : vmask_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      imask_q <= '0;
      vmask_q <= '1;
      vis_q   <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      imask_q <= imask_d;
      vmask_q <= vmask_d;
      vis_q   <= flags_d & vmask_d;
      irq_q   <= |(flags_d & imask_d);
    end
  end
endmodule

// File: rtl/cmdstat_ctrl.sv
module cmdstat_ctrl
  import cmdstat_pkg::*;
#(
  parameter int WIN_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  cmd_t             cmd,
  input  logic [WIN_W-1:0] win_arg,
  output logic [WIN_W-1:0] win_q,
  output logic             rx_en_q,
  output logic             tx_en_q,
  output logic             rx_rst_q,
  output logic             tx_rst_q,
  output logic             glob_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      win_q    <= '0;
      rx_en_q  <= 1'b0;
      tx_en_q  <= 1'b0;
      rx_rst_q <= 1'b0;
      tx_rst_q <= 1'b0;
      glob_q   <= 1'b0;
    end else begin
      rx_rst_q <= cmd.rx_rst;
      tx_rst_q <= cmd.tx_rst;
      glob_q   <= cmd.glob;
      if (cmd.glob) begin
        win_q   <= '0;
        rx_en_q <= 1'b0;
        tx_en_q <= 1'b0;
      end else begin
        if (cmd.win) win_q <= win_arg;
        if (cmd.rx_on) rx_en_q <= 1'b1;
        else if (cmd.rx_off || cmd.rx_rst) rx_en_q <= 1'b0;
        if (cmd.tx_on) tx_en_q <= 1'b1;
        else if (cmd.tx_off || cmd.tx_rst) tx_en_q <= 1'b0;
      end
    end
  end

  // R9: receiver reset leaves the receiver disabled
  a_r9_rx_rst_disables: assert property (@(posedge clk) disable iff (rst)
    rx_rst_q |-> !rx_en_q);
  // R10: transmitter reset leaves the transmitter disabled
  a_r10_tx_rst_disables: assert property (@(posedge clk) disable iff (rst)
    tx_rst_q |-> !tx_en_q);
endmodule

// File: rtl/cmdstat_port.sv
module cmdstat_port
  import cmdstat_pkg::*;
#(
  parameter int RST_CYCLES = 8,
  parameter int WIN_W      = 3,
  parameter int EVT_N      = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr,
  input  logic [WORD_W-1:0] cmd_data,
  input  logic [EVT_N-1:0]  evt_pulse,
  output logic [WORD_W-1:0] status,
  output logic              irq,
  output logic              rx_enable,
  output logic              tx_enable,
  output logic              rx_reset_pulse,
  output logic              tx_reset_pulse,
  output logic              global_reset_pulse
);
  localparam int PAD_W   = WORD_W - WIN_W - 1 - EVT_N - 1;
  localparam int REQ_IDX = 5;

  cmd_t             cmd;
  logic             start, long_op, busy;
  logic [ARG_W-1:0] arg;
  logic [WIN_W-1:0] win_q;
  logic [EVT_N-1:0] vis_q;
  logic             unused_arg_bits;

  assign unused_arg_bits = ^{arg[ARG_W-1:EVT_N+1], arg[0]};

  cmdstat_decode u_dec (
    .wr(cmd_wr), .data(cmd_data), .busy(busy),
    .cmd(cmd), .start(start), .long_op(long_op), .arg(arg)
  );

  cmdstat_busy #(.RST_CYCLES(RST_CYCLES)) u_busy (
    .clk(clk), .rst(rst), .start(start), .long_op(long_op), .busy(busy)
  );

  cmdstat_events #(.EVT_N(EVT_N), .REQ_IDX(REQ_IDX)) u_evt (
    .clk(clk), .rst(rst), .clr_all(cmd.glob), .ev_in(evt_pulse),
    .arg_bits(arg[EVT_N:1]), .ack_en(cmd.ack), .req_en(cmd.req),
    .imask_en(cmd.imask), .vmask_en(cmd.vmask),
    .vis_q(vis_q), .irq_q(irq)
  );

  cmdstat_ctrl #(.WIN_W(WIN_W)) u_ctrl (
    .clk(clk), .rst(rst), .cmd(cmd), .win_arg(arg[WIN_W-1:0]),
    .win_q(win_q), .rx_en_q(rx_enable), .tx_en_q(tx_enable),
    .rx_rst_q(rx_reset_pulse), .tx_rst_q(tx_reset_pulse),
    .glob_q(global_reset_pulse)
  );

  assign status = {win_q, busy, {PAD_W{1'b0}}, vis_q, irq};

  // R3: a write while busy leaves the window unchanged
  a_r3_busy_ignores: assert property (@(posedge clk) disable iff (rst)
    (busy && cmd_wr) |=> $stable(status[WORD_W-1:WORD_W-WIN_W]));
  // R11: global reset returns window and enables to their defaults
  a_r11_glob_state: assert property (@(posedge clk) disable iff (rst)
    global_reset_pulse |-> (win_q == '0 && !rx_enable && !tx_enable && !irq));
  // R9: reset pulses last one cycle
  a_r9_rx_pulse_single: assert property (@(posedge clk) disable iff (rst)
    rx_reset_pulse |=> !rx_reset_pulse);
  // R10: reset pulses last one cycle
  a_r10_tx_pulse_single: assert property (@(posedge clk) disable iff (rst)
    tx_reset_pulse |=> !tx_reset_pulse);
endmodule

// File: tb/tb_cmdstat_port.sv
module tb_cmdstat_port;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_wr;
  logic [15:0] cmd_data;
  logic [6:0]  evt_pulse;
  logic [15:0] status;
  logic        irq, rx_enable, tx_enable;
  logic        rx_reset_pulse, tx_reset_pulse, global_reset_pulse;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  cmdstat_port dut (
    .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd_data(cmd_data),
    .evt_pulse(evt_pulse), .status(status), .irq(irq),
    .rx_enable(rx_enable), .tx_enable(tx_enable),
    .rx_reset_pulse(rx_reset_pulse), .tx_reset_pulse(tx_reset_pulse),
    .global_reset_pulse(global_reset_pulse)
  );

  typedef struct packed {
    logic [15:0] cmd;
    logic        wr;
    logic [6:0]  ev;
    logic [3:0]  gap;
    logic [15:0] st;
    logic        irq;
    logic        rx;
    logic        tx;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{16'h0805, 1'b1, 7'h00, 4'd1, 16'hA000, 1'b0, 1'b0, 1'b0}, // R2 window 5
    '{16'h0000, 1'b0, 7'h01, 4'd0, 16'hA002, 1'b0, 1'b0, 1'b0}, // R4 adapter failure
    '{16'h0000, 1'b0, 7'h40, 4'd0, 16'hA082, 1'b0, 1'b0, 1'b0}, // R4 stats update
    '{16'h7002, 1'b1, 7'h00, 4'd1, 16'hA083, 1'b1, 1'b0, 1'b0}, // R7 unmask bit1
    '{16'h7880, 1'b1, 7'h00, 4'd1, 16'hA081, 1'b1, 1'b0, 1'b0}, // R8 hide bit1
    '{16'h78FE, 1'b1, 7'h00, 4'd1, 16'hA083, 1'b1, 1'b0, 1'b0}, // R8 show all
    '{16'h6802, 1'b1, 7'h00, 4'd1, 16'hA080, 1'b0, 1'b0, 1'b0}, // R5 ack bit1
    '{16'h6000, 1'b1, 7'h00, 4'd1, 16'hA0C0, 1'b0, 1'b0, 1'b0}, // R6 request
    '{16'h7040, 1'b1, 7'h00, 4'd1, 16'hA0C1, 1'b1, 1'b0, 1'b0}, // R7 unmask bit6
    '{16'h68FF, 1'b1, 7'h00, 4'd1, 16'hA000, 1'b0, 1'b0, 1'b0}, // R5 ack all
    '{16'h27FF, 1'b1, 7'h00, 4'd1, 16'hA000, 1'b0, 1'b1, 1'b0}, // R9 rx on, arg ignored
    '{16'h4800, 1'b1, 7'h00, 4'd1, 16'hA000, 1'b0, 1'b1, 1'b1}, // R10 tx on
    '{16'h1003, 1'b1, 7'h00, 4'd0, 16'hA000, 1'b0, 1'b1, 1'b1}, // R12 op 2
    '{16'h4000, 1'b1, 7'h00, 4'd0, 16'hA000, 1'b0, 1'b1, 1'b1}, // R12 op 8
    '{16'hF807, 1'b1, 7'h00, 4'd0, 16'hA000, 1'b0, 1'b1, 1'b1}, // R12 op 31
    '{16'h2800, 1'b1, 7'h00, 4'd8, 16'hA000, 1'b0, 1'b0, 1'b1}, // R9 rx reset
    '{16'h5000, 1'b1, 7'h00, 4'd1, 16'hA000, 1'b0, 1'b0, 1'b0}, // R10 tx off
    '{16'h2000, 1'b1, 7'h00, 4'd1, 16'hA000, 1'b0, 1'b1, 1'b0}, // R9 rx on
    '{16'h1800, 1'b1, 7'h00, 4'd1, 16'hA000, 1'b0, 1'b0, 1'b0}, // R9 rx off
    '{16'h4800, 1'b1, 7'h00, 4'd1, 16'hA000, 1'b0, 1'b0, 1'b1}  // R10 tx on
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic drive(input logic [15:0] w, input logic wr, input logic [6:0] ev);
    cmd_data = w; cmd_wr = wr; evt_pulse = ev;
    @(negedge clk);
    cmd_wr = 1'b0; cmd_data = '0; evt_pulse = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; cmd_wr = 1'b0; cmd_data = '0; evt_pulse = '0;
    idle(3);
    rst = 1'b0;
    idle(1);

    // R1 reset state
    chk("R1 status", status, 16'h0000);
    chk("R1 outputs", {13'd0, irq, rx_enable, tx_enable}, 16'h0000);
    chk("R1 pulses", {13'd0, rx_reset_pulse, tx_reset_pulse, global_reset_pulse}, 16'h0000);

    // Vector table
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].cmd, VEC[i].wr, VEC[i].ev);
      idle(int'(VEC[i].gap));
      chk($sformatf("R2-vector %0d status", i), status, VEC[i].st);
      chk($sformatf("vector %0d irq/rx/tx (R7 R9 R10)", i),
          {13'd0, irq, rx_enable, tx_enable}, {13'd0, VEC[i].irq, VEC[i].rx, VEC[i].tx});
    end

    // R3 busy for one cycle; write while busy is dropped
    drive(16'h0803, 1'b1, 7'h00);
    chk("R3 busy after window", status, 16'h7000);
    drive(16'h0806, 1'b1, 7'h00);
    chk("R3 write while busy dropped", status, 16'h6000);

    // R3 long busy after receiver reset, R9 pulse
    drive(16'h2800, 1'b1, 7'h00);
    chk("R9 rx reset pulse", {15'd0, rx_reset_pulse}, 16'h0001);
    chk("R3 long busy start", {15'd0, status[12]}, 16'h0001);
    idle(1);
    chk("R9 rx reset pulse ends", {15'd0, rx_reset_pulse}, 16'h0000);
    idle(6);
    chk("R3 busy at cycle 8", {15'd0, status[12]}, 16'h0001);
    idle(1);
    chk("R3 busy cleared after 8", {15'd0, status[12]}, 16'h0000);

    // R10 tx reset pulse
    drive(16'h5800, 1'b1, 7'h00);
    chk("R10 tx reset pulse", {14'd0, tx_reset_pulse, tx_enable}, 16'h0002);
    idle(8);

    // R5 event and acknowledge in the same cycle
    drive(16'h0000, 1'b0, 7'h02);
    drive(16'h6804, 1'b1, 7'h02);
    idle(1);
    chk("R5 same-cycle event wins", status, 16'h6004);
    drive(16'h6804, 1'b1, 7'h00);
    idle(1);
    chk("R5 ack clears", status, 16'h6000);

    // R11 global reset
    drive(16'h2000, 1'b1, 7'h00); idle(1);
    drive(16'h70FE, 1'b1, 7'h00); idle(1);
    drive(16'h7800, 1'b1, 7'h00); idle(1);
    drive(16'h0000, 1'b0, 7'h04);
    chk("R8 hidden event still raises irq", {status[7:0], 7'd0, irq}, 16'h0101);
    drive(16'h0000, 1'b1, 7'h00);
    chk("R11 global pulse", {13'd0, global_reset_pulse, rx_enable, irq}, 16'h0004);
    chk("R11 status during reset", status, 16'h1000);
    idle(8);
    chk("R11 status after reset", status, 16'h0000);
    drive(16'h0000, 1'b0, 7'h40);
    chk("R11 masks back to default", {status[7:0], 7'd0, irq}, 16'h8000);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule